// File: doc/BRIEF.md
# Formatted UART Receive Engine

This block recovers asynchronous serial characters from a receive line. It runs from a 16x oversampling clock enable, registers the incoming line before use, finds a start bit on a falling edge, confirms it at mid-bit, and then samples every following bit at its centre. The character format can be set at run time: 7 or 8 data bits, parity on or off with four parity kinds, and one or two stop bits.

Each finished character becomes one word of DATA_W+1 bits: an error flag on top and the data below it. The word is announced by a single-cycle push strobe, ready to be written into a receive FIFO. A character with a bad parity bit or a low stop bit is still delivered, with its error flag set. An idle flag shows when the engine is waiting for a start bit. The format inputs are expected to stay steady while a character is being received.

Top module: `uart_rx_framer`

## Requirements
- R1: While `rst` is high the registered line is held at the mark level (1), `rx_idle` is 1, `rx_push` is 0 and `rx_word` is 0, whatever level `rxd_in` has.
- R2: Bit timing advances only on cycles where `tick16` is 1. With `tick16` held at 0, activity on `rxd_in` produces no push and leaves `rx_idle` at 1. Every push follows a cycle in which `tick16` was 1.
- R3: A start is taken on a 1-to-0 change of the line seen at a tick. If the line reads 1 again at the 8th tick after that, the engine returns to idle without a push.
- R4: Data bits arrive LSB first, one per 16 ticks, each sampled at its centre. For a clean 8-bit frame `rx_word` is {0, data}. `rx_push` is high for exactly one cycle per character, and `rx_word` changes only in that cycle.
- R5: With `fmt_len7` = 1 seven data bits are received and bit 7 of `rx_word` is 0.
- R6: With `fmt_par_en` = 1 one parity bit follows the data. `fmt_par_kind` encodes 00 odd, 01 even, 10 space (bit is 0), 11 mark (bit is 1). A received parity bit that differs from the expected one sets bit 8 of the word.
- R7: With `fmt_stop2` = 1 two stop bits are sampled, otherwise one. A 0 in any stop bit sets bit 8, and the character is still pushed.
- R8: `rx_idle` is 0 from the confirmed start until the character ends, and it is 1 in the cycle in which `rx_push` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Clock enable at 16x the baud rate |
| rxd_in | input | 1 | Serial receive line, asynchronous |
| fmt_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| fmt_stop2 | input | 1 | 1 selects two stop bits |
| fmt_par_en | input | 1 | 1 enables the parity bit |
| fmt_par_kind | input | 2 | 00 odd, 01 even, 10 space, 11 mark |
| rx_word | output | DATA_W+1 | {error flag, data} of the last character |
| rx_push | output | 1 | One-cycle write strobe per character |
| rx_idle | output | 1 | 1 while waiting for a start bit |

## Verification
A line change reaches the engine two clocks later, through the input registers. It is acted on at the next tick. The push for a character comes out one clock after the tick that samples the centre of its last stop bit, which is roughly half a bit period into that stop bit. The bench holds every line level for a full bit period of 32 clocks (16 ticks, one tick every other clock). A monitor records each push on the falling clock edge. The bench compares the captured word and the push count only after the trailing idle bit, well past the point where the push is due. The busy state of `rx_idle` is sampled at the end of the start bit, when the start has been confirmed for half a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   localparam logic [1:0] PAR_ODD   = 2'b00;
   localparam logic [1:0] PAR_EVEN  = 2'b01;
   localparam logic [1:0] PAR_SPACE = 2'b10;
   localparam logic [1:0] PAR_MARK  = 2'b11;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain_q <= 1'b1;
            else     chain_q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        kind,
   input  logic              rcv_bit,
   output logic              mismatch
);
   logic want;

   always_comb begin
      unique case (kind)
         PAR_ODD:   want = ~(^data);
         PAR_EVEN:  want = ^data;
         PAR_SPACE: want = 1'b0;
         default:   want = 1'b1;
      endcase
      mismatch = want ^ rcv_bit;
   end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import uart_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              line,
   input  logic              len7,
   input  logic              stop2,
   input  logic              par_en,
   input  logic              par_bad,
   output logic [DATA_W-1:0] data_aligned,
   output logic [DATA_W:0]   word,
   output logic              push,
   output logic              idle
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_8   = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_7   = IDX_W'(DATA_W - 2);

   rx_state_t         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shift_q;
   logic              err_q;
   logic              second_q;
   logic              prev_q;
   logic [IDX_W-1:0]  last_idx;
   logic              at_centre;

   assign last_idx     = len7 ? LAST_7 : LAST_8;
   assign data_aligned = len7 ? (shift_q >> 1) : shift_q;
   assign at_centre    = (cnt_q == LAST_CNT);
   assign idle         = (state_q == RX_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= RX_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         shift_q  <= '0;
         err_q    <= 1'b0;
         second_q <= 1'b0;
         prev_q   <= 1'b1;
         word     <= '0;
         push     <= 1'b0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            prev_q <= line;
            unique case (state_q)
               RX_IDLE: begin
                  if (prev_q && !line) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == MID_CNT) begin
                     cnt_q <= '0;
                     if (line) begin
                        state_q <= RX_IDLE;
                     end else begin
                        state_q <= RX_DATA;
                        idx_q   <= '0;
                        err_q   <= 1'b0;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (at_centre) begin
                     cnt_q   <= '0;
                     shift_q <= {line, shift_q[DATA_W-1:1]};
                     if (idx_q == last_idx) begin
                        state_q  <= par_en ? RX_PAR : RX_STOP;
                        second_q <= 1'b0;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (at_centre) begin
                     cnt_q   <= '0;
                     state_q <= RX_STOP;
                     if (par_bad) err_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (at_centre) begin
                     cnt_q <= '0;
                     if (!line) err_q <= 1'b1;
                     if (stop2 && !second_q) begin
                        second_q <= 1'b1;
                     end else begin
                        word    <= {err_q | ~line, data_aligned};
                        push    <= 1'b1;
                        state_q <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick16,
   input  logic              rxd_in,
   input  logic              fmt_len7,
   input  logic              fmt_stop2,
   input  logic              fmt_par_en,
   input  logic [1:0]        fmt_par_kind,
   output logic [DATA_W:0]   rx_word,
   output logic              rx_push,
   output logic              rx_idle
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("uart_rx_framer: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("uart_rx_framer: SYNC_STAGES must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("uart_rx_framer: DATA_W must be at least 2");
      end
   endgenerate

   logic              line_s;
   logic              par_bad;
   logic [DATA_W-1:0] data_aligned;

   rx_line_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk  (clk),
      .rst  (rst),
      .din  (rxd_in),
      .dout (line_s)
   );

   rx_parity_chk #(
      .DATA_W(DATA_W)
   ) par_i (
      .data     (data_aligned),
      .kind     (fmt_par_kind),
      .rcv_bit  (line_s),
      .mismatch (par_bad)
   );

   rx_frame_fsm #(
      .DATA_W     (DATA_W),
      .OVERSAMPLE (OVERSAMPLE)
   ) fsm_i (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick16),
      .line         (line_s),
      .len7         (fmt_len7),
      .stop2        (fmt_stop2),
      .par_en       (fmt_par_en),
      .par_bad      (par_bad),
      .data_aligned (data_aligned),
      .word         (rx_word),
      .push         (rx_push),
      .idle         (rx_idle)
   );
endmodule

// File: rtl/uart_rx_framer_chk.sv
module uart_rx_framer_chk #(
   parameter int DATA_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic            tick16,
   input logic            fmt_len7,
   input logic [DATA_W:0] rx_word,
   input logic            rx_push,
   input logic            rx_idle
);
   logic seen_edge = 1'b0;

   always @(posedge clk) seen_edge <= 1'b1;

   always @(negedge clk) begin
      if (rst && seen_edge) begin
         AST_RESET_STATE: assert (rx_idle && !rx_push && rx_word == '0); // R1
      end
   end

   AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
      rx_push |-> $past(tick16)); // R2

   AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rx_push |=> !rx_push); // R4

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_word) |-> rx_push); // R4

   AST_SEVEN_MSB: assert property (@(posedge clk) disable iff (rst)
      (rx_push && fmt_len7) |-> !rx_word[DATA_W-1]); // R5

   AST_PUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
      rx_push |-> rx_idle); // R8
endmodule

bind uart_rx_framer uart_rx_framer_chk #(
   .DATA_W(DATA_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .tick16   (tick16),
   .fmt_len7 (fmt_len7),
   .rx_word  (rx_word),
   .rx_push  (rx_push),
   .rx_idle  (rx_idle)
);

// File: tb/uart_rx_framer_tb_top.sv
module uart_rx_framer_tb_top;
   localparam int BIT_CLKS = 32;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick16 = 1'b0;
   logic       gate = 1'b0;
   logic       rxd = 1'b1;
   logic       len7 = 1'b0;
   logic       stop2 = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] kind = 2'b00;
   logic [8:0] rx_word;
   logic       rx_push;
   logic       rx_idle;

   int tests = 0;
   int fails = 0;
   int push_cnt = 0;
   logic [8:0] last_word = '0;
   logic busy_seen = 1'b0;

   uart_rx_framer dut_i (
      .clk          (clk),
      .rst          (rst),
      .tick16       (tick16),
      .rxd_in       (rxd),
      .fmt_len7     (len7),
      .fmt_stop2    (stop2),
      .fmt_par_en   (par_en),
      .fmt_par_kind (kind),
      .rx_word      (rx_word),
      .rx_push      (rx_push),
      .rx_idle      (rx_idle)
   );

   always #4 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         tick16 = gate ? 1'b0 : ~tick16;
      end
   end

   always @(negedge clk) begin
      if (!rst && rx_push) begin
         push_cnt  = push_cnt + 1;
         last_word = rx_word;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rxd = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] data, input logic l7, input logic pe,
                             input logic [1:0] k, input logic s2, input logic bad_par,
                             input logic [1:0] bad_stop);
      logic [7:0] dm;
      logic p;
      int n;
      len7 = l7; stop2 = s2; par_en = pe; kind = k;
      n = l7 ? 7 : 8;
      dm = l7 ? (data & 8'h7F) : data;
      case (k)
         2'b00:   p = ($countones(dm) % 2) == 0;
         2'b01:   p = ($countones(dm) % 2) == 1;
         2'b10:   p = 1'b0;
         default: p = 1'b1;
      endcase
      hold_bit(1'b0);
      busy_seen = !rx_idle;
      for (int i = 0; i < n; i++) hold_bit(data[i]);
      if (pe) hold_bit(p ^ bad_par);
      hold_bit(!bad_stop[0]);
      if (s2) hold_bit(!bad_stop[1]);
      hold_bit(1'b1);
   endtask

   task automatic expect_frame(input string req, input logic [7:0] data, input logic l7,
                               input logic pe, input logic [1:0] k, input logic s2,
                               input logic bad_par, input logic [1:0] bad_stop);
      int n0;
      logic [8:0] exp;
      n0 = push_cnt;
      exp = {bad_par | (bad_stop != 2'b00), l7 ? (data & 8'h7F) : data};
      send_frame(data, l7, pe, k, s2, bad_par, bad_stop);
      chk({req, " push count"}, push_cnt - n0, 1);
      chk({req, " word"}, int'(last_word), int'(exp));
      chk("R8 busy during frame", int'(busy_seen), 1);
      chk("R8 idle after frame", int'(rx_idle), 1);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      chk("R1 idle in reset", int'(rx_idle), 1);
      chk("R1 push in reset", int'(rx_push), 0);
      chk("R1 word in reset", int'(rx_word), 0);
      rxd = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      chk("R1 idle after release", int'(rx_idle), 1);
   endtask

   task automatic t_basic();
      expect_frame("R4 8N1 a5", 8'hA5, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
      expect_frame("R4 8N1 3c", 8'h3C, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
      expect_frame("R4 8N1 01", 8'h01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
   endtask

   task automatic t_seven();
      expect_frame("R5 7E1", 8'hD5, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00);
      expect_frame("R5 7O2", 8'hFF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 2'b00);
   endtask

   task automatic t_parity();
      expect_frame("R6 odd ok",    8'h81, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00);
      expect_frame("R6 even ok",   8'h83, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00);
      expect_frame("R6 space ok",  8'h5A, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 2'b00);
      expect_frame("R6 mark ok",   8'h5A, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 2'b00);
      expect_frame("R6 odd bad",   8'h81, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 2'b00);
      expect_frame("R6 even bad",  8'h07, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 2'b00);
      expect_frame("R6 space bad", 8'h10, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 2'b00);
      expect_frame("R6 mark bad",  8'h10, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 2'b00);
   endtask

   task automatic t_stop();
      expect_frame("R7 8N2 ok",        8'h96, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00);
      expect_frame("R7 8N2 2nd bad",   8'h96, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b10);
      expect_frame("R7 8N2 1st bad",   8'h69, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01);
      expect_frame("R7 8N1 stop bad",  8'hC3, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01);
   endtask

   task automatic t_false_start();
      int n0;
      n0 = push_cnt;
      len7 = 1'b0; stop2 = 1'b0; par_en = 1'b0;
      rxd = 1'b0;
      repeat (8) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);
      chk("R3 no push on glitch", push_cnt - n0, 0);
      chk("R3 idle after glitch", int'(rx_idle), 1);
      expect_frame("R3 recovery", 8'h4E, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
   endtask

   task automatic t_tick_gate();
      int n0;
      n0 = push_cnt;
      gate = 1'b1;
      send_frame(8'h00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
      chk("R2 no push without ticks", push_cnt - n0, 0);
      chk("R2 idle without ticks", int'(rx_idle), 1);
      gate = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      expect_frame("R2 ticks resumed", 8'hE7, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_seven();
      t_parity();
      t_stop();
      t_false_start();
      t_tick_gate();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule